// File: doc/BRIEF.md
# Dual-Source Output Buffer Interrupt Arbiter

This block sits between two byte producers and a host. The producers are a keyboard channel and an auxiliary pointing-device channel, and both feed a single host-readable data port. Each producer drops bytes into its own one-entry holding register, which carries a valid flag. The two valid flags together form a two-bit pending mask. The host reads the data port, and the block steers that read to the right holding register, so the host sees one byte stream.

The block keeps a controller mode register. Combining the pending mask with that register, it produces the buffer-full flags of a status byte and their copies in an output-port byte. It also drives two level-sensitive interrupt lines: the keyboard line is meant for IRQ 1 and the auxiliary line for IRQ 12.

When both producers hold data, the keyboard always has priority. The auxiliary flag and the auxiliary interrupt appear only when the auxiliary channel is the single pending source. Command decoding and the device-side serial links are handled outside this block. They reach it only as load strobes, mode writes and interface on/off pulses.

Top module: `obuf_irq_arbiter`

## Requirements
- R1: `pend_mask[0]` equals the keyboard valid flag and `pend_mask[1]` equals the auxiliary valid flag. A load strobe sets the flag of its own channel and captures the byte at the next rising edge.
- R2: One cycle after the pending mask is nonzero, `stat_bits[0]` and `outp_bits[4]` are 1. When the mask is zero they are 0. Every bit of both bytes other than bits 0, 4 and 5 stays 0.
- R3: `stat_bits[5]` and `outp_bits[5]` are 1 only when the previous cycle's mask was exactly 2'b10, meaning the auxiliary channel alone was pending.
- R4: `irq_aux` is a registered level. It is 1 exactly when the previous cycle's mask was 2'b10 and mode bit 1 was set.
- R5: `irq_key` is a registered level. It is 1 exactly when the previous cycle's mask had bit 0 set, mode bit 0 was set and mode bit 4 was clear. The two interrupt lines are never high together.
- R6: `host_rd_data` shows the auxiliary byte when the mask is 2'b10 and the keyboard byte in every other case. It follows the state with no added delay.
- R7: `host_rd` pops the channel that `host_rd_data` selects, and that channel's valid flag clears at the next edge. A load in the same cycle on the same channel takes priority, leaving the flag set with the new byte. A read with nothing pending changes nothing.
- R8: The mode register resets to 8'h03. `mode_wr` replaces the whole byte. Otherwise `key_if_off` sets bit 4, and otherwise `key_if_on` clears bit 4. The flags and interrupts are recomputed from the new mode in the following cycle.
- R9: While `rst` is high, at each edge both valid flags clear, all flag bits clear and both interrupt lines go low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_load | input | 1 | Keyboard channel byte strobe |
| key_byte | input | 8 | Keyboard channel byte |
| aux_load | input | 1 | Auxiliary channel byte strobe |
| aux_byte | input | 8 | Auxiliary channel byte |
| host_rd | input | 1 | Host data-port read (pops the selected channel) |
| host_rd_data | output | 8 | Byte presented on the data port |
| mode_wr | input | 1 | Mode register write strobe |
| mode_wdata | input | 8 | Mode register write value |
| key_if_off | input | 1 | Keyboard interface disable pulse (sets mode bit 4) |
| key_if_on | input | 1 | Keyboard interface enable pulse (clears mode bit 4) |
| mode_val | output | 8 | Current mode register |
| pend_mask | output | 2 | Pending mask, bit 0 keyboard, bit 1 auxiliary |
| stat_bits | output | 8 | Status byte: bit 0 any-full, bit 5 auxiliary-full |
| outp_bits | output | 8 | Output-port byte: bit 4 any-full, bit 5 auxiliary-full |
| irq_key | output | 1 | Keyboard interrupt level |
| irq_aux | output | 1 | Auxiliary interrupt level |

## Verification
The assertions assume the control strobes are never X after reset. They also assume that a simultaneous mode write and interface pulse settle by the stated priority: write first, then off, then on. The stimulus drives every input as a clean 0/1 at the falling edge. It mixes random loads, reads on an empty buffer, mode writes and on/off pulses at rates that keep both channels alternating between full and empty. Directed cases cover both channels pending together, a read colliding with a load, and the keyboard interrupt being masked by the disable bit while data waits.

// File: rtl/obuf_arb_pkg.sv
package obuf_arb_pkg;
  localparam int DATA_W = 8;
  localparam int MODE_W = 8;
  localparam int NSRC   = 2;

  // channel indices inside the pending mask
  localparam int SRC_KEY = 0;
  localparam int SRC_AUX = 1;

  // mode bits consulted by the arbiter
  localparam int MB_KEY_IRQ_EN = 0;
  localparam int MB_AUX_IRQ_EN = 1;
  localparam int MB_KEY_OFF    = 4;

  // status and output-port flag positions
  localparam int ST_ANY_FULL = 0;
  localparam int ST_AUX_FULL = 5;
  localparam int OP_ANY_FULL = 4;
  localparam int OP_AUX_FULL = 5;

  typedef logic [NSRC-1:0] pend_t;
  localparam pend_t PEND_AUX_ONLY = pend_t'(1 << SRC_AUX);
endpackage

// File: rtl/obuf_src_hold.sv
module obuf_src_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] load_byte,
  input  logic          pop,
  output logic          valid,
  output logic [DW-1:0] byte_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid  <= 1'b0;
      byte_q <= '0;
    end else if (load) begin
      valid  <= 1'b1;
      byte_q <= load_byte;
    end else if (pop) begin
      valid  <= 1'b0;
    end
  end

  // R7
  pop_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (pop && !load) |=> !valid);

  // R1
  load_sets_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (valid && byte_q == $past(load_byte)));
endmodule

// File: rtl/obuf_mode_reg.sv
module obuf_mode_reg #(
  parameter int               MW      = 8,
  parameter logic [MW-1:0]    RST_VAL = 8'h03,
  parameter int               OFF_BIT = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [MW-1:0] wdata,
  input  logic          if_off,
  input  logic          if_on,
  output logic [MW-1:0] mode_q
);
  always_ff @(posedge clk) begin
    if (rst)          mode_q <= RST_VAL;
    else if (wr)      mode_q <= wdata;
    else if (if_off)  mode_q[OFF_BIT] <= 1'b1;
    else if (if_on)   mode_q[OFF_BIT] <= 1'b0;
  end

  // R8
  off_sets_chk: assert property (@(posedge clk) disable iff (rst)
    (if_off && !wr) |=> mode_q[OFF_BIT]);

  // R8
  on_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (if_on && !if_off && !wr) |=> !mode_q[OFF_BIT]);
endmodule

// File: rtl/obuf_flag_gen.sv
module obuf_flag_gen
  import obuf_arb_pkg::*;
#(
  parameter int MW = MODE_W,
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  pend_t         pend,
  input  logic [MW-1:0] mode,
  output logic [SW-1:0] stat_q,
  output logic [SW-1:0] outp_q,
  output logic          irq_key_q,
  output logic          irq_aux_q
);
  logic any_full, aux_only;
  logic key_irq_d, aux_irq_d;
  logic [SW-1:0] stat_d, outp_d;

  always_comb begin
    any_full  = |pend;
    aux_only  = (pend == PEND_AUX_ONLY);
    aux_irq_d = aux_only && mode[MB_AUX_IRQ_EN];
    key_irq_d = any_full && !aux_only && mode[MB_KEY_IRQ_EN] && !mode[MB_KEY_OFF];
    stat_d = '0;
    outp_d = '0;
    stat_d[ST_ANY_FULL] = any_full;
    stat_d[ST_AUX_FULL] = aux_only;
    outp_d[OP_ANY_FULL] = any_full;
    outp_d[OP_AUX_FULL] = aux_only;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q    <= '0;
      outp_q    <= '0;
      irq_key_q <= 1'b0;
      irq_aux_q <= 1'b0;
    end else begin
      stat_q    <= stat_d;
      outp_q    <= outp_d;
      irq_key_q <= key_irq_d;
      irq_aux_q <= aux_irq_d;
    end
  end

  // R5
  irq_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({irq_key_q, irq_aux_q}));

  // R4
  aux_irq_src_chk: assert property (@(posedge clk) disable iff (rst)
    pend != PEND_AUX_ONLY |=> !irq_aux_q);

  // R3
  aux_flag_nest_chk: assert property (@(posedge clk) disable iff (rst)
    stat_q[ST_AUX_FULL] |-> stat_q[ST_ANY_FULL]);

  // R5
  key_masked_chk: assert property (@(posedge clk) disable iff (rst)
    mode[MB_KEY_OFF] |=> !irq_key_q);
endmodule

// File: rtl/obuf_irq_arbiter.sv
module obuf_irq_arbiter
  import obuf_arb_pkg::*;
#(
  parameter int               DW       = DATA_W,
  parameter int               MW       = MODE_W,
  parameter int               SW       = 8,
  parameter logic [MW-1:0]    MODE_RST = 8'h03
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          key_load,
  input  logic [DW-1:0] key_byte,
  input  logic          aux_load,
  input  logic [DW-1:0] aux_byte,
  input  logic          host_rd,
  output logic [DW-1:0] host_rd_data,
  input  logic          mode_wr,
  input  logic [MW-1:0] mode_wdata,
  input  logic          key_if_off,
  input  logic          key_if_on,
  output logic [MW-1:0] mode_val,
  output logic [1:0]    pend_mask,
  output logic [SW-1:0] stat_bits,
  output logic [SW-1:0] outp_bits,
  output logic          irq_key,
  output logic          irq_aux
);
  logic [NSRC-1:0]         src_load;
  logic [NSRC-1:0][DW-1:0] src_in;
  logic [NSRC-1:0]         src_pop;
  logic [NSRC-1:0][DW-1:0] src_byte;
  pend_t                   pend;
  logic                    pick_aux;

  assign src_load[SRC_KEY] = key_load;
  assign src_load[SRC_AUX] = aux_load;
  assign src_in[SRC_KEY]   = key_byte;
  assign src_in[SRC_AUX]   = aux_byte;

  assign pick_aux               = (pend == PEND_AUX_ONLY);
  assign src_pop[SRC_AUX]       = host_rd && pick_aux;
  assign src_pop[SRC_KEY]       = host_rd && !pick_aux;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    obuf_src_hold #(.DW(DW)) hold_i (
      .clk       (clk),
      .rst       (rst),
      .load      (src_load[g]),
      .load_byte (src_in[g]),
      .pop       (src_pop[g]),
      .valid     (pend[g]),
      .byte_q    (src_byte[g])
    );
  end

  assign host_rd_data = pick_aux ? src_byte[SRC_AUX] : src_byte[SRC_KEY];
  assign pend_mask    = pend;

  obuf_mode_reg #(.MW(MW), .RST_VAL(MODE_RST), .OFF_BIT(MB_KEY_OFF)) mode_i (
    .clk    (clk),
    .rst    (rst),
    .wr     (mode_wr),
    .wdata  (mode_wdata),
    .if_off (key_if_off),
    .if_on  (key_if_on),
    .mode_q (mode_val)
  );

  obuf_flag_gen #(.MW(MW), .SW(SW)) flags_i (
    .clk       (clk),
    .rst       (rst),
    .pend      (pend),
    .mode      (mode_val),
    .stat_q    (stat_bits),
    .outp_q    (outp_bits),
    .irq_key_q (irq_key),
    .irq_aux_q (irq_aux)
  );

  // R6
  rd_steer_chk: assert property (@(posedge clk) disable iff (rst)
    (pend == 2'b11) |-> host_rd_data == src_byte[SRC_KEY]);

  // R7
  rd_key_first_chk: assert property (@(posedge clk) disable iff (rst)
    (host_rd && pend == 2'b11 && !key_load && !aux_load) |=> pend == 2'b10);
endmodule

// File: tb/obuf_irq_arbiter_tb.sv
module obuf_irq_arbiter_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic key_load = 0, aux_load = 0, host_rd = 0, mode_wr = 0, key_if_off = 0, key_if_on = 0;
  logic [7:0] key_byte = 0, aux_byte = 0, mode_wdata = 0;
  logic [7:0] host_rd_data, mode_val, stat_bits, outp_bits;
  logic [1:0] pend_mask;
  logic irq_key, irq_aux;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #10 clk = ~clk;

  obuf_irq_arbiter dut_i (
    .clk(clk), .rst(rst),
    .key_load(key_load), .key_byte(key_byte),
    .aux_load(aux_load), .aux_byte(aux_byte),
    .host_rd(host_rd), .host_rd_data(host_rd_data),
    .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .key_if_off(key_if_off), .key_if_on(key_if_on),
    .mode_val(mode_val), .pend_mask(pend_mask),
    .stat_bits(stat_bits), .outp_bits(outp_bits),
    .irq_key(irq_key), .irq_aux(irq_aux)
  );

  // reference state, built from the requirements
  logic m_kv = 0, m_av = 0;
  logic [7:0] m_kb = 0, m_ab = 0, m_mode = 8'h03, m_stat = 0, m_outp = 0;
  logic m_ik = 0, m_ia = 0;

  function automatic logic [7:0] f_stat(input logic kv, input logic av);
    logic [7:0] s = 8'h00;
    s[0] = kv | av;          // R2
    s[5] = av & ~kv;         // R3
    return s;
  endfunction

  function automatic logic [7:0] f_outp(input logic kv, input logic av);
    logic [7:0] s = 8'h00;
    s[4] = kv | av;          // R2
    s[5] = av & ~kv;         // R3
    return s;
  endfunction

  function automatic logic f_iaux(input logic kv, input logic av, input logic [7:0] md);
    return av & ~kv & md[1]; // R4
  endfunction

  function automatic logic f_ikey(input logic kv, input logic [7:0] md);
    return kv & md[0] & ~md[4]; // R5
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_kv <= 0; m_av <= 0; m_kb <= 0; m_ab <= 0; m_mode <= 8'h03;
      m_stat <= 0; m_outp <= 0; m_ik <= 0; m_ia <= 0;
    end else begin
      m_stat <= f_stat(m_kv, m_av);
      m_outp <= f_outp(m_kv, m_av);
      m_ia   <= f_iaux(m_kv, m_av, m_mode);
      m_ik   <= f_ikey(m_kv, m_mode);
      if (key_load) begin m_kv <= 1; m_kb <= key_byte; end
      else if (host_rd && !(m_av && !m_kv)) m_kv <= 0;
      if (aux_load) begin m_av <= 1; m_ab <= aux_byte; end
      else if (host_rd && m_av && !m_kv) m_av <= 0;
      if (mode_wr) m_mode <= mode_wdata;
      else if (key_if_off) m_mode[4] <= 1'b1;
      else if (key_if_on) m_mode[4] <= 1'b0;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk("R1 pend_mask", 32'(pend_mask), 32'({m_av, m_kv}));
    chk("R2 stat_bits", 32'(stat_bits), 32'(m_stat));
    chk("R3 outp_bits", 32'(outp_bits), 32'(m_outp));
    chk("R4 irq_aux", 32'(irq_aux), 32'(m_ia));
    chk("R5 irq_key", 32'(irq_key), 32'(m_ik));
    chk("R6 host_rd_data", 32'(host_rd_data), 32'((m_av && !m_kv) ? m_ab : m_kb));
    chk("R8 mode_val", 32'(mode_val), 32'(m_mode));
  endtask

  task automatic idle_inputs();
    key_load = 0; aux_load = 0; host_rd = 0; mode_wr = 0; key_if_off = 0; key_if_on = 0;
  endtask

  // one cycle: check state at falling edge, then drive
  task automatic step(input logic kl, input logic [7:0] kb, input logic al, input logic [7:0] ab,
                      input logic rd, input logic mw, input logic [7:0] md,
                      input logic off, input logic on);
    @(negedge clk);
    check_all();
    key_load = kl; key_byte = kb; aux_load = al; aux_byte = ab;
    host_rd = rd; mode_wr = mw; mode_wdata = md; key_if_off = off; key_if_on = on;
  endtask

  initial begin : watchdog
    #(20 * 150000);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin : main
    int unsigned seed;
    seed = $urandom(32'h5A17);
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 stat", 32'(stat_bits), 0);
    chk("R9 outp", 32'(outp_bits), 0);
    chk("R9 irq", 32'({irq_key, irq_aux}), 0);
    chk("R9 pend", 32'(pend_mask), 0);
    chk("R8 reset mode", 32'(mode_val), 32'h03);
    rst = 0;
    // aux alone -> aux flags and aux irq (R3 R4 R6)
    step(0, 0, 1, 8'hA5, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R4 aux sole irq", 32'(irq_aux), 1);
    chk("R6 aux byte", 32'(host_rd_data), 32'hA5);
    // keyboard arrives: keyboard wins (R5 R6)
    step(1, 8'h3C, 0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R5 key wins irq", 32'({irq_key, irq_aux}), 32'b10);
    chk("R3 aux flag drop", 32'(stat_bits), 32'h01);
    // disable keyboard interface masks irq_key (R5 R8)
    step(0, 0, 0, 0, 0, 0, 0, 1, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R5 masked", 32'(irq_key), 0);
    // read pops keyboard, then aux alone (R7)
    step(0, 0, 0, 0, 1, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R7 key popped", 32'(pend_mask), 32'b10);
    // read with same-cycle aux load: load wins (R7)
    step(0, 0, 1, 8'h77, 1, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R7 load beats pop", 32'(host_rd_data), 32'h77);
    // mode write clears aux irq enable (R8 R4)
    step(0, 0, 0, 0, 0, 1, 8'h01, 1, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R8 write priority", 32'(mode_val), 32'h01);
    chk("R4 aux irq off", 32'(irq_aux), 0);
    // empty read has no effect (R7)
    step(0, 0, 0, 0, 1, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R7 empty read", 32'(pend_mask), 0);
    // random phase
    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 100) < 25, 8'($urandom), ($urandom % 100) < 25, 8'($urandom),
           ($urandom % 100) < 35, ($urandom % 100) < 5, 8'($urandom),
           ($urandom % 100) < 6, ($urandom % 100) < 6);
    end
    // mid-run reset (R9)
    @(negedge clk); idle_inputs(); rst = 1;
    @(negedge clk); @(negedge clk);
    chk("R9 rerun irq", 32'({irq_key, irq_aux}), 0);
    chk("R9 rerun pend", 32'(pend_mask), 0);
    rst = 0;
    step(0, 0, 0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule